// File: doc/BRIEF.md
# Tag-Matching Reservation Station Pool

This block is a small pool of waiting slots placed in front of a single functional unit. The issue stage hands it one renamed instruction at a time: an operation code plus, for each of two sources, either a finished value or the tag of the producer that will deliver it. Waiting instructions watch one result broadcast bus that carries a tag and a value. When a source's tag matches the bus, the source takes the value and becomes valid. An instruction whose sources are both valid may leave for the functional unit, in dataflow order rather than issue order.

The pool shows the issue stage whether it is full or empty, so issue can stall. Each cycle, one ready slot is offered to the functional unit through a valid/ready handshake. The offer carries the slot's own result tag, which is `TAG_BASE` plus the slot index, so tag value zero is never used as a producer name. A synchronous flush empties the pool in one cycle.

Top module: `rsp_pool`

## Requirements
- R1: After reset, `iss_empty` is 1, `iss_full` is 0 and `dsp_valid` is 0.
- R2: When `iss_valid` is 1 and the pool is not full, the instruction goes into the lowest-numbered free slot. `dsp_tag` reports `TAG_BASE` plus that slot index. `iss_full` is 1 exactly when every slot is occupied, and `iss_empty` is 1 exactly when none is.
- R3: A source tag of 0 marks the source as holding a valid value. A slot whose two sources are both valid is offered on the dispatch port in the cycle after it becomes so, with its opcode and both values.
- R4: While `bc_valid` is 1, every occupied slot compares each nonzero source tag with `bc_tag`. On a match the slot stores `bc_data` into that source and sets its tag to 0. All waiting consumers in all slots capture in the same cycle.
- R5: An incoming source whose nonzero tag equals `bc_tag` while `bc_valid` is 1 in the insertion cycle is stored as valid with `bc_data`.
- R6: When several slots are ready, the lowest-numbered one is offered.
- R7: An offered slot stays occupied, and `dsp_valid` stays 1, until a cycle with `dsp_ready` 1. The slot is freed at the end of that cycle.
- R8: A cycle with `flush` 1 frees every slot: in the next cycle `iss_empty` is 1 and `dsp_valid` is 0.
- R9: Three kinds of stimulus change no slot: an instruction offered while `iss_full` is 1, a broadcast whose tag matches no waiting source, and a tag on the bus while `bc_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Synchronous clear of all slots |
| iss_valid | input | 1 | Issue stage presents an instruction |
| iss_op | input | OP_W | Operation code |
| iss_tag_a | input | TAG_W | Producer tag of source A, 0 = value present |
| iss_val_a | input | DATA_W | Value of source A |
| iss_tag_b | input | TAG_W | Producer tag of source B, 0 = value present |
| iss_val_b | input | DATA_W | Value of source B |
| iss_full | output | 1 | No free slot; issue must stall |
| iss_empty | output | 1 | No occupied slot |
| bc_valid | input | 1 | Result broadcast present |
| bc_tag | input | TAG_W | Tag of the broadcast result |
| bc_data | input | DATA_W | Value of the broadcast result |
| dsp_valid | output | 1 | A ready slot is offered |
| dsp_ready | input | 1 | Functional unit accepts the offer |
| dsp_op | output | OP_W | Opcode of the offered slot |
| dsp_a | output | DATA_W | Source A value of the offered slot |
| dsp_b | output | DATA_W | Source B value of the offered slot |
| dsp_tag | output | TAG_W | Result tag of the offered slot |

## Verification
A missed tag match shows at the ports as a slot that is never offered. A slot that wakes up too early shows as an offer carrying a stale operand in `dsp_a` or `dsp_b`. Either error is visible in the first cycle after the broadcast that should or should not have woken the slot. A wrong free-slot or priority choice appears as an unexpected `dsp_tag`. A lost busy flag appears as `iss_empty` or `iss_full` disagreeing with the count of slots issued minus slots dispatched. A per-cycle reference model of the slots, kept in the bench, catches each of these in the cycle it occurs.

// File: rtl/rsp_pkg.sv
package rsp_pkg;

   localparam int DEF_ENTRIES = 4;
   localparam int DEF_DATA_W  = 16;
   localparam int DEF_TAG_W   = 3;
   localparam int DEF_OP_W    = 4;

   localparam int NUM_SRC = 2;

   function automatic int unsigned idx_width(input int unsigned n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction

   function automatic logic tag_hit(input logic [31:0] held,
                                    input logic [31:0] bus,
                                    input logic        bus_valid);
      return bus_valid && (held != 32'd0) && (held == bus);
   endfunction

endpackage

// File: rtl/rsp_pick.sv
module rsp_pick #(
   parameter int N     = 4,
   parameter int IDX_W = 2
) (
   input  logic [N-1:0]     req,
   output logic [N-1:0]     gnt,
   output logic [IDX_W-1:0] idx,
   output logic             any
);

   always_comb begin
      gnt = '0;
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            gnt    = '0;
            gnt[i] = 1'b1;
            idx    = IDX_W'(i);
         end
      end
   end

   assign any = |req;

endmodule

// File: rtl/rsp_src.sv
module rsp_src #(
   parameter int DATA_W = 16,
   parameter int TAG_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              snoop,
   input  logic [TAG_W-1:0]  ld_tag,
   input  logic [DATA_W-1:0] ld_val,
   input  logic              bc_valid,
   input  logic [TAG_W-1:0]  bc_tag,
   input  logic [DATA_W-1:0] bc_data,
   output logic [TAG_W-1:0]  tag_q,
   output logic [DATA_W-1:0] val_q
);

   logic hit_ld;
   logic hit_held;

   assign hit_ld   = rsp_pkg::tag_hit(32'(ld_tag), 32'(bc_tag), bc_valid);
   assign hit_held = snoop && rsp_pkg::tag_hit(32'(tag_q), 32'(bc_tag), bc_valid);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tag_q <= '0;
         val_q <= '0;
      end else if (load) begin
         if (hit_ld) begin
            tag_q <= '0;
            val_q <= bc_data;
         end else begin
            tag_q <= ld_tag;
            val_q <= ld_val;
         end
      end else if (hit_held) begin
         tag_q <= '0;
         val_q <= bc_data;
      end
   end

   p_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && hit_held) |=> (tag_q == '0) && (val_q == $past(bc_data)));

   p_early_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (load && hit_ld) |=> (tag_q == '0) && (val_q == $past(bc_data)));

   p_valid_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && tag_q == '0) |=> (tag_q == '0) && $stable(val_q));

endmodule

// File: rtl/rsp_entry.sv
module rsp_entry #(
   parameter int DATA_W = 16,
   parameter int TAG_W  = 3,
   parameter int OP_W   = 4
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   flush,
   input  logic                                   load,
   input  logic                                   clear,
   input  logic [OP_W-1:0]                        ld_op,
   input  logic [rsp_pkg::NUM_SRC-1:0][TAG_W-1:0]  ld_tag,
   input  logic [rsp_pkg::NUM_SRC-1:0][DATA_W-1:0] ld_val,
   input  logic                                   bc_valid,
   input  logic [TAG_W-1:0]                       bc_tag,
   input  logic [DATA_W-1:0]                      bc_data,
   output logic                                   busy,
   output logic                                   ready,
   output logic [OP_W-1:0]                        op,
   output logic [rsp_pkg::NUM_SRC-1:0][DATA_W-1:0] val
);

   localparam int NS = rsp_pkg::NUM_SRC;

   logic [NS-1:0][TAG_W-1:0] tag;
   logic [NS-1:0]            src_ok;

   for (genvar s = 0; s < NS; s++) begin : g_src
      rsp_src #(.DATA_W(DATA_W), .TAG_W(TAG_W)) i_src (
         .clk      (clk),
         .rst_n    (rst_n),
         .load     (load),
         .snoop    (busy),
         .ld_tag   (ld_tag[s]),
         .ld_val   (ld_val[s]),
         .bc_valid (bc_valid),
         .bc_tag   (bc_tag),
         .bc_data  (bc_data),
         .tag_q    (tag[s]),
         .val_q    (val[s])
      );
      assign src_ok[s] = (tag[s] == '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         op   <= '0;
      end else if (flush) begin
         busy <= 1'b0;
      end else if (load) begin
         busy <= 1'b1;
         op   <= ld_op;
      end else if (clear) begin
         busy <= 1'b0;
      end
   end

   assign ready = busy && (&src_ok);

   p_free_on_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (clear && !load) |=> !busy);

   p_flush_frees_r8: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !busy);

endmodule

// File: rtl/rsp_pool.sv
module rsp_pool #(
   parameter int N_ENTRIES = rsp_pkg::DEF_ENTRIES,
   parameter int DATA_W    = rsp_pkg::DEF_DATA_W,
   parameter int TAG_W     = rsp_pkg::DEF_TAG_W,
   parameter int OP_W      = rsp_pkg::DEF_OP_W,
   parameter int TAG_BASE  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              iss_valid,
   input  logic [OP_W-1:0]   iss_op,
   input  logic [TAG_W-1:0]  iss_tag_a,
   input  logic [DATA_W-1:0] iss_val_a,
   input  logic [TAG_W-1:0]  iss_tag_b,
   input  logic [DATA_W-1:0] iss_val_b,
   output logic              iss_full,
   output logic              iss_empty,
   input  logic              bc_valid,
   input  logic [TAG_W-1:0]  bc_tag,
   input  logic [DATA_W-1:0] bc_data,
   output logic              dsp_valid,
   input  logic              dsp_ready,
   output logic [OP_W-1:0]   dsp_op,
   output logic [DATA_W-1:0] dsp_a,
   output logic [DATA_W-1:0] dsp_b,
   output logic [TAG_W-1:0]  dsp_tag
);

   localparam int N     = N_ENTRIES;
   localparam int NS    = rsp_pkg::NUM_SRC;
   localparam int IDX_W = rsp_pkg::idx_width(N);

   logic [N-1:0]     busy_vec;
   logic [N-1:0]     ready_vec;
   logic [N-1:0]     free_gnt;
   logic [N-1:0]     rdy_gnt;
   logic [N-1:0]     load_vec;
   logic [N-1:0]     clear_vec;
   logic [IDX_W-1:0] free_idx;
   logic [IDX_W-1:0] rdy_idx;
   logic             any_free;
   logic             accept;
   logic             fire;

   logic [OP_W-1:0]              op_arr  [N];
   logic [NS-1:0][DATA_W-1:0]    val_arr [N];
   logic [NS-1:0][TAG_W-1:0]     in_tag;
   logic [NS-1:0][DATA_W-1:0]    in_val;

   assign in_tag = {iss_tag_b, iss_tag_a};
   assign in_val = {iss_val_b, iss_val_a};

   rsp_pick #(.N(N), .IDX_W(IDX_W)) i_free_pick (
      .req (~busy_vec),
      .gnt (free_gnt),
      .idx (free_idx),
      .any (any_free)
   );

   rsp_pick #(.N(N), .IDX_W(IDX_W)) i_ready_pick (
      .req (ready_vec),
      .gnt (rdy_gnt),
      .idx (rdy_idx),
      .any (dsp_valid)
   );

   assign accept    = iss_valid && any_free && !flush;
   assign fire      = dsp_valid && dsp_ready && !flush;
   assign load_vec  = accept ? free_gnt : '0;
   assign clear_vec = fire ? rdy_gnt : '0;

   for (genvar e = 0; e < N; e++) begin : g_entry
      rsp_entry #(.DATA_W(DATA_W), .TAG_W(TAG_W), .OP_W(OP_W)) i_entry (
         .clk      (clk),
         .rst_n    (rst_n),
         .flush    (flush),
         .load     (load_vec[e]),
         .clear    (clear_vec[e]),
         .ld_op    (iss_op),
         .ld_tag   (in_tag),
         .ld_val   (in_val),
         .bc_valid (bc_valid),
         .bc_tag   (bc_tag),
         .bc_data  (bc_data),
         .busy     (busy_vec[e]),
         .ready    (ready_vec[e]),
         .op       (op_arr[e]),
         .val      (val_arr[e])
      );
   end

   assign iss_full  = !any_free;
   assign iss_empty = !(|busy_vec);
   assign dsp_op    = op_arr[rdy_idx];
   assign dsp_a     = val_arr[rdy_idx][0];
   assign dsp_b     = val_arr[rdy_idx][1];
   assign dsp_tag   = TAG_W'(TAG_BASE) + TAG_W'(rdy_idx);

   p_lowest_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
      dsp_valid |-> ((ready_vec & ((N'(1) << rdy_idx) - N'(1))) == '0));

   p_offer_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (dsp_valid && !dsp_ready && !flush) |=> dsp_valid);

   p_insert_seen_r2: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !iss_empty);

   p_full_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_full && !(dsp_valid && dsp_ready) && !flush) |=> iss_full);

   p_flush_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (iss_empty && !dsp_valid));

endmodule

// File: tb/test_rsp_pool.sv
module test_rsp_pool;

   localparam int N = 4;

   typedef struct packed {
      logic        iv;
      logic [3:0]  op;
      logic [2:0]  ta;
      logic [15:0] va;
      logic [2:0]  tb;
      logic [15:0] vb;
      logic        bv;
      logic [2:0]  bt;
      logic [15:0] bd;
      logic        rdy;
   } vec_t;

   // Walk covering R2, R3, R4, R6 (and R5 at step 11) through the model.
   localparam vec_t VEC [17] = '{
      '{1'b1, 4'h1, 3'd0, 16'h0011, 3'd5, 16'h0000, 1'b0, 3'd0, 16'h0000, 1'b1},
      '{1'b1, 4'h2, 3'd5, 16'h0000, 3'd6, 16'h0000, 1'b0, 3'd0, 16'h0000, 1'b1},
      '{1'b1, 4'h3, 3'd0, 16'h0033, 3'd0, 16'h0303, 1'b1, 3'd7, 16'h0777, 1'b0},
      '{1'b0, 4'h0, 3'd0, 16'h0000, 3'd0, 16'h0000, 1'b1, 3'd5, 16'h0055, 1'b0},
      '{1'b0, 4'h0, 3'd0, 16'h0000, 3'd0, 16'h0000, 1'b0, 3'd0, 16'h0000, 1'b0},
      '{1'b0, 4'h0, 3'd0, 16'h0000, 3'd0, 16'h0000, 1'b0, 3'd0, 16'h0000, 1'b1},
      '{1'b0, 4'h0, 3'd0, 16'h0000, 3'd0, 16'h0000, 1'b1, 3'd6, 16'h0066, 1'b1},
      '{1'b0, 4'h0, 3'd0, 16'h0000, 3'd0, 16'h0000, 1'b0, 3'd0, 16'h0000, 1'b1},
      '{1'b0, 4'h0, 3'd0, 16'h0000, 3'd0, 16'h0000, 1'b0, 3'd0, 16'h0000, 1'b1},
      '{1'b1, 4'h4, 3'd6, 16'h0000, 3'd6, 16'h0000, 1'b0, 3'd0, 16'h0000, 1'b1},
      '{1'b1, 4'h5, 3'd0, 16'h00AA, 3'd6, 16'h0000, 1'b0, 3'd0, 16'h0000, 1'b1},
      '{1'b1, 4'h6, 3'd6, 16'h0000, 3'd0, 16'h00BB, 1'b1, 3'd6, 16'h00C6, 1'b1},
      '{1'b0, 4'h0, 3'd0, 16'h0000, 3'd0, 16'h0000, 1'b0, 3'd0, 16'h0000, 1'b1},
      '{1'b1, 4'h7, 3'd0, 16'h0001, 3'd0, 16'h0002, 1'b0, 3'd0, 16'h0000, 1'b1},
      '{1'b0, 4'h0, 3'd0, 16'h0000, 3'd0, 16'h0000, 1'b0, 3'd0, 16'h0000, 1'b1},
      '{1'b0, 4'h0, 3'd0, 16'h0000, 3'd0, 16'h0000, 1'b0, 3'd0, 16'h0000, 1'b1},
      '{1'b0, 4'h0, 3'd0, 16'h0000, 3'd0, 16'h0000, 1'b0, 3'd0, 16'h0000, 1'b1}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flush = 1'b0;
   logic        iss_valid = 1'b0;
   logic [3:0]  iss_op = '0;
   logic [2:0]  iss_tag_a = '0;
   logic [15:0] iss_val_a = '0;
   logic [2:0]  iss_tag_b = '0;
   logic [15:0] iss_val_b = '0;
   logic        iss_full;
   logic        iss_empty;
   logic        bc_valid = 1'b0;
   logic [2:0]  bc_tag = '0;
   logic [15:0] bc_data = '0;
   logic        dsp_valid;
   logic        dsp_ready = 1'b0;
   logic [3:0]  dsp_op;
   logic [15:0] dsp_a;
   logic [15:0] dsp_b;
   logic [2:0]  dsp_tag;

   int n_cmp = 0;
   int n_bad = 0;

   logic        m_busy [N];
   logic [3:0]  m_op   [N];
   logic [2:0]  m_ta   [N];
   logic [15:0] m_va   [N];
   logic [2:0]  m_tb   [N];
   logic [15:0] m_vb   [N];

   always #5 clk = ~clk;

   rsp_pool i_rsp_pool (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush),
      .iss_valid (iss_valid),
      .iss_op    (iss_op),
      .iss_tag_a (iss_tag_a),
      .iss_val_a (iss_val_a),
      .iss_tag_b (iss_tag_b),
      .iss_val_b (iss_val_b),
      .iss_full  (iss_full),
      .iss_empty (iss_empty),
      .bc_valid  (bc_valid),
      .bc_tag    (bc_tag),
      .bc_data   (bc_data),
      .dsp_valid (dsp_valid),
      .dsp_ready (dsp_ready),
      .dsp_op    (dsp_op),
      .dsp_a     (dsp_a),
      .dsp_b     (dsp_b),
      .dsp_tag   (dsp_tag)
   );

   task automatic cmp(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic vec_t mk(input logic iv, input logic [3:0] op,
                               input logic [2:0] ta, input logic [15:0] va,
                               input logic [2:0] tb, input logic [15:0] vb,
                               input logic bv, input logic [2:0] bt,
                               input logic [15:0] bd, input logic rdy);
      return '{iv, op, ta, va, tb, vb, bv, bt, bd, rdy};
   endfunction

   localparam vec_t IDLE = '{1'b0, 4'h0, 3'd0, 16'h0, 3'd0, 16'h0, 1'b0, 3'd0, 16'h0, 1'b0};

   task automatic model_check(output logic ev, output int ei);
      logic any_busy = 1'b0;
      logic all_busy = 1'b1;
      ev = 1'b0;
      ei = 0;
      for (int i = N - 1; i >= 0; i--) begin
         any_busy = any_busy | m_busy[i];
         all_busy = all_busy & m_busy[i];
         if (m_busy[i] && m_ta[i] == 3'd0 && m_tb[i] == 3'd0) begin
            ev = 1'b1;
            ei = i;
         end
      end
      cmp("R2 empty flag", 32'(iss_empty), 32'(!any_busy));
      cmp("R2 full flag", 32'(iss_full), 32'(all_busy));
      cmp("R3 dispatch valid", 32'(dsp_valid), 32'(ev));
      if (ev) begin
         cmp("R6 dispatch tag", 32'(dsp_tag), 32'(ei + 1));
         cmp("R3 dispatch op", 32'(dsp_op), 32'(m_op[ei]));
         cmp("R4 operand a", 32'(dsp_a), 32'(m_va[ei]));
         cmp("R4 operand b", 32'(dsp_b), 32'(m_vb[ei]));
      end
   endtask

   task automatic drive(input vec_t v, input logic fl);
      iss_valid = v.iv;
      iss_op    = v.op;
      iss_tag_a = v.ta;
      iss_val_a = v.va;
      iss_tag_b = v.tb;
      iss_val_b = v.vb;
      bc_valid  = v.bv;
      bc_tag    = v.bt;
      bc_data   = v.bd;
      dsp_ready = v.rdy;
      flush     = fl;
   endtask

   task automatic step(input vec_t v, input logic fl);
      logic ev;
      int   ei;
      logic pre_busy [N];
      logic pre_full;
      int   slot;
      @(negedge clk);
      drive(v, fl);
      #1;
      model_check(ev, ei);
      pre_full = 1'b1;
      for (int i = 0; i < N; i++) begin
         pre_busy[i] = m_busy[i];
         pre_full = pre_full & m_busy[i];
      end
      @(posedge clk);
      if (fl) begin
         for (int i = 0; i < N; i++) m_busy[i] = 1'b0;
      end else begin
         if (ev && v.rdy) m_busy[ei] = 1'b0;
         for (int i = 0; i < N; i++) begin
            if (m_busy[i] && v.bv) begin
               if (m_ta[i] != 3'd0 && m_ta[i] == v.bt) begin m_ta[i] = 3'd0; m_va[i] = v.bd; end
               if (m_tb[i] != 3'd0 && m_tb[i] == v.bt) begin m_tb[i] = 3'd0; m_vb[i] = v.bd; end
            end
         end
         if (v.iv && !pre_full) begin
            slot = -1;
            for (int i = N - 1; i >= 0; i--) if (!pre_busy[i]) slot = i;
            m_busy[slot] = 1'b1;
            m_op[slot]   = v.op;
            if (v.bv && v.ta != 3'd0 && v.ta == v.bt) begin m_ta[slot] = 3'd0; m_va[slot] = v.bd; end
            else begin m_ta[slot] = v.ta; m_va[slot] = v.va; end
            if (v.bv && v.tb != 3'd0 && v.tb == v.bt) begin m_tb[slot] = 3'd0; m_vb[slot] = v.bd; end
            else begin m_tb[slot] = v.tb; m_vb[slot] = v.vb; end
         end
      end
      #1;
   endtask

   task automatic peek();
      @(negedge clk);
      drive(IDLE, 1'b0);
      #1;
   endtask

   initial begin
      #(200000 * 10);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < N; i++) begin
         m_busy[i] = 1'b0; m_op[i] = '0; m_ta[i] = '0; m_va[i] = '0; m_tb[i] = '0; m_vb[i] = '0;
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1: reset state
      cmp("R1 empty after reset", 32'(iss_empty), 32'd1);
      cmp("R1 full after reset", 32'(iss_full), 32'd0);
      cmp("R1 no dispatch after reset", 32'(dsp_valid), 32'd0);

      for (int k = 0; k < 17; k++) step(VEC[k], 1'b0);

      // R7: offer held while the unit is not ready
      step(mk(1'b1, 4'h8, 3'd0, 16'h0101, 3'd0, 16'h0202, 1'b0, 3'd0, 16'h0, 1'b0), 1'b0);
      peek();
      cmp("R7 offer raised", 32'(dsp_valid), 32'd1);
      step(IDLE, 1'b0);
      step(IDLE, 1'b0);
      peek();
      cmp("R7 offer still held", 32'(dsp_valid), 32'd1);
      cmp("R7 same slot held", 32'(dsp_tag), 32'd1);
      step(mk(1'b0, 4'h0, 3'd0, 16'h0, 3'd0, 16'h0, 1'b0, 3'd0, 16'h0, 1'b1), 1'b0);
      peek();
      cmp("R7 slot freed after handshake", 32'(iss_empty), 32'd1);

      // R9: issue while full, non-matching and unqualified broadcasts
      for (int k = 0; k < N; k++)
         step(mk(1'b1, 4'(9 + k), 3'd5, 16'h0, 3'd0, 16'(k), 1'b0, 3'd0, 16'h0, 1'b0), 1'b0);
      step(mk(1'b1, 4'hF, 3'd0, 16'hDEAD, 3'd0, 16'hBEEF, 1'b0, 3'd0, 16'h0, 1'b0), 1'b0);
      step(mk(1'b0, 4'h0, 3'd0, 16'h0, 3'd0, 16'h0, 1'b1, 3'd6, 16'h6666, 1'b0), 1'b0);
      step(mk(1'b0, 4'h0, 3'd0, 16'h0, 3'd0, 16'h0, 1'b0, 3'd5, 16'h5555, 1'b0), 1'b0);
      peek();
      cmp("R9 no wakeup without match", 32'(dsp_valid), 32'd0);
      cmp("R9 still full", 32'(iss_full), 32'd1);
      step(mk(1'b0, 4'h0, 3'd0, 16'h0, 3'd0, 16'h0, 1'b1, 3'd5, 16'h5A5A, 1'b0), 1'b0);
      for (int k = 0; k < N; k++)
         step(mk(1'b0, 4'h0, 3'd0, 16'h0, 3'd0, 16'h0, 1'b0, 3'd0, 16'h0, 1'b1), 1'b0);
      peek();
      cmp("R9 instruction offered while full was dropped", 32'(iss_empty), 32'd1);

      // R5: capture in the insertion cycle
      step(mk(1'b1, 4'h3, 3'd7, 16'h0, 3'd0, 16'h0044, 1'b1, 3'd7, 16'h1234, 1'b0), 1'b0);
      peek();
      cmp("R5 ready at once", 32'(dsp_valid), 32'd1);
      cmp("R5 captured value", 32'(dsp_a), 32'h1234);
      step(mk(1'b0, 4'h0, 3'd0, 16'h0, 3'd0, 16'h0, 1'b0, 3'd0, 16'h0, 1'b1), 1'b0);

      // R8: flush clears everything
      step(mk(1'b1, 4'h1, 3'd5, 16'h0, 3'd6, 16'h0, 1'b0, 3'd0, 16'h0, 1'b0), 1'b0);
      step(mk(1'b1, 4'h2, 3'd0, 16'h7, 3'd0, 16'h8, 1'b0, 3'd0, 16'h0, 1'b0), 1'b0);
      step(IDLE, 1'b1);
      peek();
      cmp("R8 empty after flush", 32'(iss_empty), 32'd1);
      cmp("R8 no dispatch after flush", 32'(dsp_valid), 32'd0);
      step(IDLE, 1'b0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule